// File: doc/BRIEF.md
# Accumulator ALU with per-flag update mask

This block is the arithmetic and logic datapath of a small accumulator-style processor. It is purely combinational. The caller gives it an operation code, a register operand, a second operand (usually the memory operand), and the current carry flag. In the same cycle it returns the result, new values for the negative (N), overflow (V), zero (Z) and carry (C) flags, and a mask that tells the status register which of those four flags the operation is allowed to change.

The two-operand operations (add, subtract, compare, the bitwise operations and bit test) take the register operand on `opnd_a` and the second operand on `opnd_b`. The single-operand operations (shifts, rotates, increment, decrement and the load/transfer pass-through) act on `opnd_b` alone. For a shift of the accumulator, the caller routes the accumulator onto `opnd_b`.

Compare and bit test only produce flags. For these the block lowers `wr_result`, so the caller leaves the destination register untouched. All arithmetic is binary; no decimal correction is ever applied.

Top module: `flag_alu`

## Requirements
- R1: Operation code 0 (add) gives result = (a + b + carry_in) mod 256 and wr_result=1. C is bit 8 of the 9-bit sum. V=1 exactly when a and b have the same sign and the result's sign differs. The mask is 4'b1111, with bit 3=N, bit 2=V, bit 1=Z and bit 0=C.
- R2: Operation code 1 (subtract) gives result = a − b − (1 − carry_in) mod 256 and wr_result=1. C=1 means no borrow occurred. V uses the signed-overflow rule with the inverted b. The mask is 4'b1111.
- R3: Operation code 2 (compare) drives the difference a − b on result, independent of carry_in, with wr_result=0 and mask 4'b1011. C=1 exactly when a ≥ b (unsigned). V is 0.
- R4: Operation codes 3, 4 and 5 give a AND b, a OR b and a XOR b, with mask 4'b1010, wr_result=1, and C=V=0.
- R5: Operation code 6 (shift left) gives b<<1, and code 7 (logical shift right) gives b>>1. Both fill the vacated bit with 0 and put the bit shifted out into C. The mask is 4'b1011 and wr_result=1.
- R6: Operation code 8 (rotate left) and code 9 (rotate right) shift b through the carry. carry_in enters the vacated end, the bit leaving the other end becomes C, and the mask is 4'b1011.
- R7: Operation code 10 (increment) gives b+1 mod 256, and code 11 (decrement) gives b−1 mod 256. carry_in has no effect on them. The mask is 4'b1010, wr_result=1, and C=V=0.
- R8: Operation code 12 (bit test) gives N = b bit 7, V = b bit 6, Z = ((a AND b) == 0), mask 4'b1110, wr_result=0, and C=0. It drives a AND b on result.
- R9: Operation code 13 (pass) gives result = b with mask 4'b1010, wr_result=1, and C=V=0.
- R10: For every defined operation other than bit test, N equals result bit 7 whenever mask bit 3 is set, and Z equals (result == 0) whenever mask bit 1 is set. Any flag whose mask bit is clear is driven 0.
- R11: Operation codes 14 and 15 are unused. They give result 0, mask 0, all four flags 0, and wr_result=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (see requirements) |
| opnd_a | input | WIDTH | Register operand for two-operand operations |
| opnd_b | input | WIDTH | Memory operand; sole source for single-operand operations |
| carry_in | input | 1 | Current carry flag |
| result | output | WIDTH | Operation result |
| wr_result | output | 1 | High when the result is to be written to a register |
| flag_n | output | 1 | New negative flag |
| flag_v | output | 1 | New overflow flag |
| flag_z | output | 1 | New zero flag |
| flag_c | output | 1 | New carry flag |
| upd_mask | output | 4 | Flags this operation updates: bit 3 N, bit 2 V, bit 1 Z, bit 0 C |

## Verification
The embedded assertions assume that all inputs are at known 0/1 values whenever they are evaluated. They skip any evaluation in which an input is unknown. They also assume that the operation code is stable for the whole evaluation of the combinational cone. The bench drives every input from a single process and changes them together. It then waits a settling interval before sampling, and it never leaves an input undriven. As a result, every assertion sees a complete, known combination: each of the 16 operation codes, every pair of 8-bit operands, and both carry values.

// File: rtl/flag_alu_pkg.sv
// Package: shared operation codes, mask bit positions and internal selects
// for the flag ALU. Assumes a 4-bit operation code.
package flag_alu_pkg;

    localparam int OP_W   = 4;
    localparam int MASK_W = 4;

    // Bit positions inside the update mask
    localparam int UPD_C = 0;
    localparam int UPD_Z = 1;
    localparam int UPD_V = 2;
    localparam int UPD_N = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_CMP  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_ASL  = 4'd6,
        OP_LSR  = 4'd7,
        OP_ROL  = 4'd8,
        OP_ROR  = 4'd9,
        OP_INC  = 4'd10,
        OP_DEC  = 4'd11,
        OP_BIT  = 4'd12,
        OP_PASS = 4'd13
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_sel_e;

    typedef enum logic [1:0] {
        SH_ASL = 2'd0,
        SH_LSR = 2'd1,
        SH_ROL = 2'd2,
        SH_ROR = 2'd3
    } shift_sel_e;

    typedef enum logic [2:0] {
        SRC_ZERO  = 3'd0,
        SRC_ADD   = 3'd1,
        SRC_LOGIC = 3'd2,
        SRC_SHIFT = 3'd3,
        SRC_PASS  = 3'd4
    } res_src_e;

endpackage

// File: rtl/alu_adder.sv
// Module: ripple-carry adder producing sum, carry out of the top bit and
// two's-complement overflow. Assumes the caller pre-inverts the right
// operand for subtraction and picks the carry in.
module alu_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);

    logic [WIDTH:0] chain;

    assign chain[0] = cin;

    // One full-adder cell per bit
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        assign sum[i]     = lhs[i] ^ rhs[i] ^ chain[i];
        assign chain[i+1] = (lhs[i] & rhs[i]) | (chain[i] & (lhs[i] ^ rhs[i]));
    end

    assign cout = chain[WIDTH];
    assign ovf  = chain[WIDTH] ^ chain[WIDTH-1];

    // Cross-check the ripple chain against whole-word arithmetic
    always_comb begin
        if (!$isunknown({lhs, rhs, cin})) begin
            p_ripple_sum_r1: assert ({cout, sum} ==
                ({1'b0, lhs} + {1'b0, rhs} + (WIDTH+1)'(cin)))
                else $error("adder sum mismatch");
            p_sign_ovf_r2: assert (ovf == ((lhs[WIDTH-1] == rhs[WIDTH-1]) &&
                                           (sum[WIDTH-1] != lhs[WIDTH-1])))
                else $error("adder overflow mismatch");
        end
    end

endmodule

// File: rtl/alu_logic.sv
// Module: bitwise AND / OR / XOR unit. Assumes sel is one of the three
// defined logic selects; any other value yields zero.
module alu_logic
    import flag_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    input  logic_sel_e       sel,
    output logic [WIDTH-1:0] res
);

    // Select the bitwise function
    always_comb begin
        case (sel)
            LG_AND:  res = lhs & rhs;
            LG_OR:   res = lhs | rhs;
            LG_XOR:  res = lhs ^ rhs;
            default: res = '0;
        endcase
    end

    // AND can only clear bits; OR can only set them
    always_comb begin
        if (!$isunknown({lhs, rhs, sel})) begin
            p_and_subset_r4: assert (sel != LG_AND || (res & ~lhs) == '0)
                else $error("AND set a bit absent from lhs");
            p_or_superset_r4: assert (sel != LG_OR || (lhs & ~res) == '0)
                else $error("OR cleared a bit of lhs");
        end
    end

endmodule

// File: rtl/alu_shift.sv
// Module: one-bit shifter/rotator. Shifts fill with zero; rotates move
// carry-in into the vacated end. The bit leaving the word is returned as
// carry out in every mode.
module alu_shift
    import flag_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] src,
    input  logic             cin,
    input  shift_sel_e       kind,
    output logic [WIDTH-1:0] res,
    output logic             cout
);

    logic fill;

    // Choose the bit entering the vacated end
    assign fill = (kind == SH_ROL || kind == SH_ROR) ? cin : 1'b0;

    // Direction select and outgoing bit
    always_comb begin
        if (kind == SH_ASL || kind == SH_ROL) begin
            res  = {src[WIDTH-2:0], fill};
            cout = src[WIDTH-1];
        end else begin
            res  = {fill, src[WIDTH-1:1]};
            cout = src[0];
        end
    end

    // Rotation through carry conserves the number of set bits
    always_comb begin
        if (!$isunknown({src, cin, kind})) begin
            p_rot_ones_r6: assert (!(kind == SH_ROL || kind == SH_ROR) ||
                $countones({cout, res}) == $countones({cin, src}))
                else $error("rotate lost or gained a bit");
            p_shift_ones_r5: assert ((kind == SH_ROL || kind == SH_ROR) ||
                $countones({cout, res}) == $countones(src))
                else $error("shift lost or gained a bit");
        end
    end

endmodule

// File: rtl/alu_flags.sv
// Module: forms raw N/V/Z/C from the selected result and unit outputs,
// then clears every flag the update mask does not enable.
module alu_flags
    import flag_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]  res,
    input  logic [1:0]        b_top,
    input  logic              bit_mode,
    input  logic              c_from_shift,
    input  logic              add_cout,
    input  logic              add_ovf,
    input  logic              sh_cout,
    input  logic [MASK_W-1:0] mask,
    output logic              flag_n,
    output logic              flag_v,
    output logic              flag_z,
    output logic              flag_c
);

    logic raw_n, raw_v, raw_z, raw_c;

    // Raw flag sources before masking
    always_comb begin
        raw_n = bit_mode ? b_top[1] : res[WIDTH-1];
        raw_v = bit_mode ? b_top[0] : add_ovf;
        raw_z = (res == '0);
        raw_c = c_from_shift ? sh_cout : add_cout;
    end

    // Gate each flag by its mask bit
    always_comb begin
        flag_n = raw_n & mask[UPD_N];
        flag_v = raw_v & mask[UPD_V];
        flag_z = raw_z & mask[UPD_Z];
        flag_c = raw_c & mask[UPD_C];
    end

endmodule

// File: rtl/flag_alu.sv
// Module: top of the flag ALU. Decodes the operation code into operand
// steering, unit selects, result source, update mask and write enable.
// Purely combinational; assumes the caller registers the result and
// applies the mask to its status register.
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [OP_W-1:0]   op_sel,
    input  logic [WIDTH-1:0]  opnd_a,
    input  logic [WIDTH-1:0]  opnd_b,
    input  logic              carry_in,
    output logic [WIDTH-1:0]  result,
    output logic              wr_result,
    output logic              flag_n,
    output logic              flag_v,
    output logic              flag_z,
    output logic              flag_c,
    output logic [MASK_W-1:0] upd_mask
);

    localparam logic [MASK_W-1:0] M_NVZC = 4'b1111;
    localparam logic [MASK_W-1:0] M_NZC  = 4'b1011;
    localparam logic [MASK_W-1:0] M_NZ   = 4'b1010;
    localparam logic [MASK_W-1:0] M_NVZ  = 4'b1110;

    alu_op_e           op;
    logic [WIDTH-1:0]  add_l, add_r, add_sum;
    logic              add_ci, add_cout, add_ovf;
    logic_sel_e        lg_sel;
    logic [WIDTH-1:0]  lg_res;
    shift_sel_e        sh_kind;
    logic [WIDTH-1:0]  sh_res;
    logic              sh_cout;
    res_src_e          src;
    logic              bit_mode, c_from_shift;

    assign op = alu_op_e'(op_sel);

    // Decode: operand steering, unit selects, mask and write enable
    always_comb begin
        add_l        = opnd_a;
        add_r        = opnd_b;
        add_ci       = carry_in;
        lg_sel       = LG_AND;
        sh_kind      = SH_ASL;
        src          = SRC_ZERO;
        upd_mask     = '0;
        wr_result    = 1'b0;
        bit_mode     = 1'b0;
        c_from_shift = 1'b0;
        case (op)
            OP_ADD: begin
                src = SRC_ADD; upd_mask = M_NVZC; wr_result = 1'b1;
            end
            OP_SUB: begin
                add_r = ~opnd_b;
                src = SRC_ADD; upd_mask = M_NVZC; wr_result = 1'b1;
            end
            OP_CMP: begin
                add_r = ~opnd_b; add_ci = 1'b1;
                src = SRC_ADD; upd_mask = M_NZC;
            end
            OP_AND: begin
                lg_sel = LG_AND; src = SRC_LOGIC; upd_mask = M_NZ; wr_result = 1'b1;
            end
            OP_OR: begin
                lg_sel = LG_OR; src = SRC_LOGIC; upd_mask = M_NZ; wr_result = 1'b1;
            end
            OP_XOR: begin
                lg_sel = LG_XOR; src = SRC_LOGIC; upd_mask = M_NZ; wr_result = 1'b1;
            end
            OP_ASL: begin
                sh_kind = SH_ASL; src = SRC_SHIFT; c_from_shift = 1'b1;
                upd_mask = M_NZC; wr_result = 1'b1;
            end
            OP_LSR: begin
                sh_kind = SH_LSR; src = SRC_SHIFT; c_from_shift = 1'b1;
                upd_mask = M_NZC; wr_result = 1'b1;
            end
            OP_ROL: begin
                sh_kind = SH_ROL; src = SRC_SHIFT; c_from_shift = 1'b1;
                upd_mask = M_NZC; wr_result = 1'b1;
            end
            OP_ROR: begin
                sh_kind = SH_ROR; src = SRC_SHIFT; c_from_shift = 1'b1;
                upd_mask = M_NZC; wr_result = 1'b1;
            end
            OP_INC: begin
                add_l = opnd_b; add_r = '0; add_ci = 1'b1;
                src = SRC_ADD; upd_mask = M_NZ; wr_result = 1'b1;
            end
            OP_DEC: begin
                add_l = opnd_b; add_r = '1; add_ci = 1'b0;
                src = SRC_ADD; upd_mask = M_NZ; wr_result = 1'b1;
            end
            OP_BIT: begin
                lg_sel = LG_AND; src = SRC_LOGIC; bit_mode = 1'b1;
                upd_mask = M_NVZ;
            end
            OP_PASS: begin
                src = SRC_PASS; upd_mask = M_NZ; wr_result = 1'b1;
            end
            default: ;
        endcase
    end

    alu_adder #(.WIDTH(WIDTH)) u_adder (
        .lhs  (add_l),
        .rhs  (add_r),
        .cin  (add_ci),
        .sum  (add_sum),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .lhs (opnd_a),
        .rhs (opnd_b),
        .sel (lg_sel),
        .res (lg_res)
    );

    alu_shift #(.WIDTH(WIDTH)) u_shift (
        .src  (opnd_b),
        .cin  (carry_in),
        .kind (sh_kind),
        .res  (sh_res),
        .cout (sh_cout)
    );

    // Result multiplexer
    always_comb begin
        case (src)
            SRC_ADD:   result = add_sum;
            SRC_LOGIC: result = lg_res;
            SRC_SHIFT: result = sh_res;
            SRC_PASS:  result = opnd_b;
            default:   result = '0;
        endcase
    end

    alu_flags #(.WIDTH(WIDTH)) u_flags (
        .res          (result),
        .b_top        (opnd_b[WIDTH-1:WIDTH-2]),
        .bit_mode     (bit_mode),
        .c_from_shift (c_from_shift),
        .add_cout     (add_cout),
        .add_ovf      (add_ovf),
        .sh_cout      (sh_cout),
        .mask         (upd_mask),
        .flag_n       (flag_n),
        .flag_v       (flag_v),
        .flag_z       (flag_z),
        .flag_c       (flag_c)
    );

    // Port-level properties tying the decode to the flag outputs
    always_comb begin
        if (!$isunknown({op_sel, opnd_a, opnd_b, carry_in})) begin
            p_cmp_order_r3: assert (op != OP_CMP ||
                (flag_z == (opnd_a == opnd_b) && flag_c == (opnd_a >= opnd_b)
                 && !wr_result && !flag_v))
                else $error("compare flags disagree with operand order");
            p_logic_no_cv_r4: assert (!(op == OP_AND || op == OP_OR || op == OP_XOR) ||
                (!flag_c && !flag_v))
                else $error("logic op touched C or V");
            p_bit_copy_r8: assert (op != OP_BIT ||
                (flag_n == opnd_b[WIDTH-1] && flag_v == opnd_b[WIDTH-2] && !wr_result))
                else $error("bit test did not copy operand bits");
            p_nz_track_r10: assert (op == OP_BIT ||
                ((!upd_mask[UPD_N] || flag_n == result[WIDTH-1]) &&
                 (!upd_mask[UPD_Z] || flag_z == (result == '0))))
                else $error("N/Z do not follow result");
            p_unused_quiet_r11: assert (op_sel < 4'd14 ||
                (upd_mask == '0 && result == '0 && !wr_result &&
                 !flag_n && !flag_v && !flag_z && !flag_c))
                else $error("unused code produced activity");
        end
    end

endmodule

// File: tb/flag_alu_bench.sv
`timescale 1ns/1ps
// Bench: exhaustive sweep of all operation codes, operand pairs and carry
// values, with expected values computed arithmetically.
module flag_alu_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] opnd_a = '0;
    logic [7:0] opnd_b = '0;
    logic       carry_in = 1'b0;
    logic [7:0] result;
    logic       wr_result, flag_n, flag_v, flag_z, flag_c;
    logic [3:0] upd_mask;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    flag_alu #(.WIDTH(8)) u_flag_alu (
        .op_sel    (op_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .carry_in  (carry_in),
        .result    (result),
        .wr_result (wr_result),
        .flag_n    (flag_n),
        .flag_v    (flag_v),
        .flag_z    (flag_z),
        .flag_c    (flag_c),
        .upd_mask  (upd_mask)
    );

    function automatic string op_tag(input int o);
        case (o)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3, 4, 5: return "R4";
            6, 7: return "R5";
            8, 9: return "R6";
            10, 11: return "R7";
            12: return "R8";
            13: return "R9";
            default: return "R11";
        endcase
    endfunction

    // Watchdog: counts as a failure and still reports
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung (actual cycles=%0d expected <150000)", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state with zero inputs: add of zeros gives zero with Z set (R1)
        checks++;
        if (result !== 8'h00 || flag_z !== 1'b1 || upd_mask !== 4'b1111) begin
            errors++;
            $display("FAIL R1 reset state: actual r=%h z=%b m=%b expected r=00 z=1 m=1111",
                     result, flag_z, upd_mask);
        end
        #0.003;
        for (int o = 0; o < 16; o++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    for (int c = 0; c < 2; c++) begin
                        int r, s, ec, ev, en, ez, ew, em;
                        logic [11:0] got, exp;
                        op_sel = 4'(o); opnd_a = 8'(a); opnd_b = 8'(b); carry_in = c[0];
                        ec = 0; ev = 0; ew = 1; em = 0; r = 0; en = 0;
                        case (o)
                            0: begin s = a + b + c; r = s & 255; ec = s >> 8;
                                ev = (((a ^ r) & (b ^ r) & 128) != 0) ? 1 : 0; em = 15; end
                            1: begin s = a + (255 - b) + c; r = s & 255; ec = s >> 8;
                                ev = (((a ^ r) & ((255 - b) ^ r) & 128) != 0) ? 1 : 0; em = 15; end
                            2: begin s = a + (255 - b) + 1; r = s & 255; ec = s >> 8;
                                ew = 0; em = 11; end
                            3: begin r = a & b; em = 10; end
                            4: begin r = a | b; em = 10; end
                            5: begin r = a ^ b; em = 10; end
                            6: begin r = (b << 1) & 255; ec = b >> 7; em = 11; end
                            7: begin r = b >> 1; ec = b & 1; em = 11; end
                            8: begin r = ((b << 1) | c) & 255; ec = b >> 7; em = 11; end
                            9: begin r = (b >> 1) | (c << 7); ec = b & 1; em = 11; end
                            10: begin r = (b + 1) & 255; em = 10; end
                            11: begin r = (b + 255) & 255; em = 10; end
                            12: begin r = a & b; ev = (b >> 6) & 1; ew = 0; em = 14; end
                            13: begin r = b; em = 10; end
                            default: begin ew = 0; end
                        endcase
                        if (o == 12) en = b >> 7;
                        else en = (em[3]) ? (r >> 7) : 0;
                        ez = (em[1] && r == 0) ? 1 : 0;
                        if (!em[0]) ec = 0;
                        if (!em[2]) ev = 0;
                        #0.005;
                        // Result, write enable, mask, C and V per operation
                        got = {result, wr_result, upd_mask[0], flag_c, flag_v};
                        exp = {8'(r), ew[0], em[0], ec[0], ev[0]};
                        checks++;
                        if (got !== exp || upd_mask !== 4'(em)) begin
                            errors++;
                            $display("FAIL %s op=%0d a=%h b=%h c=%0d: actual r=%h w=%b m=%b c=%b v=%b expected r=%h w=%0d m=%b c=%0d v=%0d",
                                     op_tag(o), o, a, b, c, result, wr_result, upd_mask,
                                     flag_c, flag_v, r[7:0], ew, 4'(em), ec, ev);
                        end
                        // N and Z tracking with masking (R10)
                        checks++;
                        if (flag_n !== en[0] || flag_z !== ez[0]) begin
                            errors++;
                            $display("FAIL R10 op=%0d a=%h b=%h c=%0d: actual n=%b z=%b expected n=%0d z=%0d",
                                     o, a, b, c, flag_n, flag_z, en, ez);
                        end
                        #0.005;
                    end
                end
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule